// File: doc/BRIEF.md
# Palette Loader and Interrupt Status Unit

This unit runs the colour-table phase of a raster display controller. When the raster enable goes from low to high, it reads 16-bit colour-table words from memory through a simple request/acknowledge read port and writes them into an internal lookup RAM. The first word it reads also carries the pixel depth, and that depth decides how many words are read. When the table is complete, the unit sets a load-complete status flag. Depending on the selected load mode, it then pulses a start signal for the frame-data fetcher that sits downstream.

While the display runs, the lookup RAM maps 4-bit or 8-bit pixel indices to 12-bit RGB colours. The unit also owns the controller's interrupt status register. Its bits are set by event pulses from neighbouring logic and by the loader itself, and software clears them by writing ones. A single interrupt line is driven from the set bits that are enabled.

Top module: `palette_loader`

## Requirements
- R1: A colour-table fetch starts only on a low-to-high transition of `ctl_enable`, and only in load mode 0 or 1. Holding `ctl_enable` high after a load starts no further fetch.
- R2: Word k of a fetch is requested at byte address `base_addr` + 2k, and `rd_addr` is held until `rd_ack`. After the first word is accepted, `fetch_ceiling` equals `base_addr` + table bytes − 1, which is 511 for 256 entries and 31 for 16 entries.
- R3: If bits 15:12 of table word 0 equal 4'h4 (bit 15 clear and depth field 14:12 = 3'b100), the table has 256 entries and `depth_is8` is 1. Any other value gives 16 entries and `depth_is8` is 0.
- R4: `ctl_load_mode` is a 2-bit code. Mode 0 loads the table, then sets the load-complete flag and pulses `data_go`. Mode 1 loads the table and sets the flag, with no `data_go`. Mode 2 skips the table and pulses `data_go` once. Mode 3 does nothing.
- R5: Dropping `ctl_enable` during a fetch lowers `rd_req` on the next clock edge. The fetch then leaves the load-complete flag clear and gives no `data_go`.
- R6: One cycle after `pix_valid`, `rgb_valid` is high and `rgb_out` holds bits 11:0 of the stored table word. In 4-bit depth only the low four index bits are used. Word bits 15:12 never reach `rgb_out`.
- R7: The status flags sit at these bit positions: sync lost at 2, FIFO underflow at 5, load complete at 6, frame 0 done at 8 and frame 1 done at 9. Each is set one cycle after its event and stays set until cleared. All other status bits read 0.
- R8: A `stat_clr_we` write clears each status bit whose `stat_clr_data` bit is 1 and leaves the other bits unchanged. An event arriving in the same cycle as the clear wins.
- R9: `irq` is the OR of all set status bits, each masked by its enable. The load-complete flag is masked by `ctl_pal_irq_en` and the underflow flag by `ctl_unf_irq_en`. Bits 2, 8 and 9 are always enabled. `irq` changes on the same edge as the status register, so it is low in the cycle after a clearing write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_enable | input | 1 | Raster enable; its rising edge starts a load |
| ctl_load_mode | input | 2 | Load sequence selector |
| ctl_pal_irq_en | input | 1 | Interrupt enable for load complete |
| ctl_unf_irq_en | input | 1 | Interrupt enable for FIFO underflow |
| base_addr | input | AW | Byte base address of the colour table |
| rd_req | output | 1 | Read request |
| rd_addr | output | AW | Byte address of the requested word |
| rd_ack | input | 1 | Read acknowledge; `rd_data` is valid with it |
| rd_data | input | 16 | Returned table word |
| fetch_ceiling | output | AW | Inclusive last byte address of the table |
| data_go | output | 1 | One-cycle start pulse for the frame-data fetch |
| pix_valid | input | 1 | Pixel index valid |
| pix_idx | input | IDX_W | Pixel index |
| rgb_valid | output | 1 | Colour output valid |
| rgb_out | output | 12 | Looked-up RGB colour |
| depth_is8 | output | 1 | Current depth is 8 bits per pixel |
| evt_frame0 | input | 1 | Frame 0 done event pulse |
| evt_frame1 | input | 1 | Frame 1 done event pulse |
| evt_underflow | input | 1 | FIFO underflow event pulse |
| evt_sync_lost | input | 1 | Sync lost event pulse |
| stat_clr_we | input | 1 | Status clear strobe |
| stat_clr_data | input | 10 | Write-one-to-clear mask |
| status | output | 10 | Status register |
| irq | output | 1 | Interrupt output |

## Verification
The bench loads tables at both depths and then sweeps every pixel index against colours it computes itself. A depth decode that miscounts entries, or index masking that lets stale upper entries through, shows up as wrong colours or a wrong word count. Table word 0 with bit 15 set probes a depth decode that looks only at bits 14:12; such a decode would fetch 256 words instead of 16.

The bench drops enable in the middle of a fetch. A loader that cannot abort keeps requesting words, sets the load-complete flag, or pulses `data_go`. A clear written in the same cycle as an event, and a clear of one bit while its neighbour is set, catch a clear that wins the race or one that wipes the whole register. The interrupt is checked with each enable both on and off.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int WORD_W = 16;
  localparam int RGB_W  = 12;
  localparam int STAT_W = 10;

  // status bit positions (fixed: software decodes them)
  localparam int ST_SYNC = 2;
  localparam int ST_UNF  = 5;
  localparam int ST_PLD  = 6;
  localparam int ST_FR0  = 8;
  localparam int ST_FR1  = 9;

  localparam logic [STAT_W-1:0] ST_IMPL =
    STAT_W'((1 << ST_SYNC) | (1 << ST_UNF) | (1 << ST_PLD) | (1 << ST_FR0) | (1 << ST_FR1));

  // upper nibble of table word 0 that selects 8-bit depth
  localparam logic [3:0] HDR_DEPTH8 = 4'h4;

  typedef enum logic [1:0] {
    LM_BOTH = 2'd0,
    LM_PAL  = 2'd1,
    LM_DATA = 2'd2,
    LM_NONE = 2'd3
  } ld_mode_e;

  typedef enum logic {
    FS_IDLE  = 1'b0,
    FS_FETCH = 1'b1
  } fstate_e;
endpackage

// File: rtl/pal_fetch.sv
module pal_fetch
  import pal_pkg::*;
#(
  parameter int AW          = 32,
  parameter int IDX_W       = 8,
  parameter int SMALL_IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [1:0]       mode,
  input  logic [AW-1:0]    base,
  output logic             rd_req,
  output logic [AW-1:0]    rd_addr,
  input  logic             rd_ack,
  input  logic [WORD_W-1:0] rd_data,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [RGB_W-1:0] wr_rgb,
  output logic             depth8,
  output logic [AW-1:0]    ceiling,
  output logic             done_pulse,
  output logic             go_pulse
);
  localparam int N_FULL  = 1 << IDX_W;
  localparam int N_SMALL = 1 << SMALL_IDX_W;
  localparam logic [IDX_W-1:0] LAST_FULL  = IDX_W'(N_FULL - 1);
  localparam logic [IDX_W-1:0] LAST_SMALL = IDX_W'(N_SMALL - 1);
  localparam int BYTES_PER_WORD = WORD_W / 8;
  localparam logic [AW-1:0] SPAN_FULL  = AW'(BYTES_PER_WORD * N_FULL - 1);
  localparam logic [AW-1:0] SPAN_SMALL = AW'(BYTES_PER_WORD * N_SMALL - 1);
  localparam logic [AW-1:0] STEP       = AW'(BYTES_PER_WORD);

  fstate_e          state;
  ld_mode_e         mode_q;
  logic             en_q;
  logic             rise;
  logic [IDX_W-1:0] cnt;
  logic [IDX_W-1:0] last_idx;
  logic [AW-1:0]    base_q;
  logic             hdr_is8;
  logic [IDX_W-1:0] lim;
  ld_mode_e         mode_in;

  assign rise    = enable & ~en_q;
  assign mode_in = ld_mode_e'(mode);

  always_comb begin
    hdr_is8 = (rd_data[WORD_W-1:WORD_W-4] == HDR_DEPTH8);
    if (cnt == '0) lim = hdr_is8 ? LAST_FULL : LAST_SMALL;
    else           lim = last_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= FS_IDLE;
      mode_q     <= LM_NONE;
      en_q       <= 1'b0;
      cnt        <= '0;
      last_idx   <= LAST_SMALL;
      base_q     <= '0;
      rd_req     <= 1'b0;
      rd_addr    <= '0;
      wr_en      <= 1'b0;
      wr_idx     <= '0;
      wr_rgb     <= '0;
      depth8     <= 1'b0;
      ceiling    <= '0;
      done_pulse <= 1'b0;
      go_pulse   <= 1'b0;
    end else begin
      en_q       <= enable;
      wr_en      <= 1'b0;
      done_pulse <= 1'b0;
      go_pulse   <= 1'b0;
      case (state)
        FS_IDLE: begin
          if (rise) begin
            case (mode_in)
              LM_BOTH, LM_PAL: begin
                state   <= FS_FETCH;
                mode_q  <= mode_in;
                cnt     <= '0;
                base_q  <= base;
                rd_req  <= 1'b1;
                rd_addr <= base;
              end
              LM_DATA: go_pulse <= 1'b1;
              default: ;
            endcase
          end
        end
        FS_FETCH: begin
          if (!enable) begin
            state  <= FS_IDLE;
            rd_req <= 1'b0;
          end else if (rd_ack) begin
            wr_en  <= 1'b1;
            wr_idx <= cnt;
            wr_rgb <= rd_data[RGB_W-1:0];
            if (cnt == '0) begin
              depth8   <= hdr_is8;
              last_idx <= hdr_is8 ? LAST_FULL : LAST_SMALL;
              ceiling  <= base_q + (hdr_is8 ? SPAN_FULL : SPAN_SMALL);
            end
            if (cnt == lim) begin
              state      <= FS_IDLE;
              rd_req     <= 1'b0;
              done_pulse <= 1'b1;
              go_pulse   <= (mode_q == LM_BOTH);
            end else begin
              cnt     <= cnt + 1'b1;
              rd_addr <= rd_addr + STEP;
            end
          end
        end
        default: state <= FS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pal_ram.sv
module pal_ram #(
  parameter int IDX_W = 8,
  parameter int DW    = 12
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [DW-1:0]    wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] raddr,
  output logic [DW-1:0]    rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pal_status.sv
module pal_status #(
  parameter int            W    = 10,
  parameter logic [W-1:0]  IMPL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_vec,
  input  logic         clr_we,
  input  logic [W-1:0] clr_vec,
  input  logic [W-1:0] en_mask,
  output logic [W-1:0] status,
  output logic         irq
);
  logic [W-1:0] clr_eff;
  logic [W-1:0] nxt;

  always_comb begin
    clr_eff = clr_we ? clr_vec : '0;
    nxt     = ((status & ~clr_eff) | set_vec) & IMPL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= nxt;
      irq    <= |(nxt & en_mask);
    end
  end
endmodule

// File: rtl/palette_loader.sv
module palette_loader
  import pal_pkg::*;
#(
  parameter int AW          = 32,
  parameter int IDX_W       = 8,
  parameter int SMALL_IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_enable,
  input  logic [1:0]        ctl_load_mode,
  input  logic              ctl_pal_irq_en,
  input  logic              ctl_unf_irq_en,
  input  logic [AW-1:0]     base_addr,
  output logic              rd_req,
  output logic [AW-1:0]     rd_addr,
  input  logic              rd_ack,
  input  logic [15:0]       rd_data,
  output logic [AW-1:0]     fetch_ceiling,
  output logic              data_go,
  input  logic              pix_valid,
  input  logic [IDX_W-1:0]  pix_idx,
  output logic              rgb_valid,
  output logic [11:0]       rgb_out,
  output logic              depth_is8,
  input  logic              evt_frame0,
  input  logic              evt_frame1,
  input  logic              evt_underflow,
  input  logic              evt_sync_lost,
  input  logic              stat_clr_we,
  input  logic [9:0]        stat_clr_data,
  output logic [9:0]        status,
  output logic              irq
);
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [RGB_W-1:0] wr_rgb;
  logic             load_done;
  logic [IDX_W-1:0] lut_addr;
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] en_mask;

  pal_fetch #(
    .AW(AW), .IDX_W(IDX_W), .SMALL_IDX_W(SMALL_IDX_W)
  ) fetch_i (
    .clk        (clk),
    .rst        (rst),
    .enable     (ctl_enable),
    .mode       (ctl_load_mode),
    .base       (base_addr),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .rd_ack     (rd_ack),
    .rd_data    (rd_data),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_rgb     (wr_rgb),
    .depth8     (depth_is8),
    .ceiling    (fetch_ceiling),
    .done_pulse (load_done),
    .go_pulse   (data_go)
  );

  // 4-bit depth uses only the low index bits
  always_comb begin
    lut_addr = pix_idx;
    if (!depth_is8) lut_addr = {{(IDX_W-SMALL_IDX_W){1'b0}}, pix_idx[SMALL_IDX_W-1:0]};
  end

  pal_ram #(.IDX_W(IDX_W), .DW(RGB_W)) ram_i (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_idx),
    .wdata (wr_rgb),
    .re    (pix_valid),
    .raddr (lut_addr),
    .rdata (rgb_out)
  );

  always_ff @(posedge clk) begin
    if (rst) rgb_valid <= 1'b0;
    else     rgb_valid <= pix_valid;
  end

  always_comb begin
    set_vec          = '0;
    set_vec[ST_SYNC] = evt_sync_lost;
    set_vec[ST_UNF]  = evt_underflow;
    set_vec[ST_PLD]  = load_done;
    set_vec[ST_FR0]  = evt_frame0;
    set_vec[ST_FR1]  = evt_frame1;
    en_mask          = '0;
    en_mask[ST_SYNC] = 1'b1;
    en_mask[ST_UNF]  = ctl_unf_irq_en;
    en_mask[ST_PLD]  = ctl_pal_irq_en;
    en_mask[ST_FR0]  = 1'b1;
    en_mask[ST_FR1]  = 1'b1;
  end

  pal_status #(.W(STAT_W), .IMPL(ST_IMPL)) stat_i (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_vec),
    .clr_we  (stat_clr_we),
    .clr_vec (stat_clr_data),
    .en_mask (en_mask),
    .status  (status),
    .irq     (irq)
  );
endmodule

// File: rtl/palette_loader_chk.sv
module palette_loader_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          ctl_enable,
  input logic          rd_req,
  input logic          rd_ack,
  input logic [AW-1:0] rd_addr,
  input logic          data_go,
  input logic          pix_valid,
  input logic          rgb_valid,
  input logic          evt_underflow,
  input logic          evt_frame0,
  input logic          stat_clr_we,
  input logic [9:0]    stat_clr_data,
  input logic [9:0]    status,
  input logic          irq
);
  // R2: address held while a request waits
  p_addr_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_ack && ctl_enable) |=> (rd_req && $stable(rd_addr)));

  // R5: enable low ends any request
  p_abort_r5: assert property (@(posedge clk) disable iff (rst)
    !ctl_enable |=> !rd_req);

  // R4: start pulse never overlaps an open fetch
  p_go_no_fetch_r4: assert property (@(posedge clk) disable iff (rst)
    data_go |-> !rd_req);

  // R6: one-cycle lookup latency
  p_rgb_lat_r6: assert property (@(posedge clk) disable iff (rst)
    pix_valid |=> rgb_valid);

  // R7: frame-0 flag holds until cleared
  p_fr0_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (status[8] && !(stat_clr_we && stat_clr_data[8])) |=> status[8]);

  // R8: a clear without a new event empties the bit
  p_w1c_r8: assert property (@(posedge clk) disable iff (rst)
    (stat_clr_we && stat_clr_data[5] && !evt_underflow) |=> !status[5]);

  // R8: event wins over clear
  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (evt_frame0 && stat_clr_we && stat_clr_data[8]) |=> status[8]);

  // R9: no interrupt without a status bit
  p_irq_src_r9: assert property (@(posedge clk) disable iff (rst)
    (status == '0) |-> !irq);
endmodule

bind palette_loader palette_loader_chk #(.AW(AW)) chk_i (
  .clk           (clk),
  .rst           (rst),
  .ctl_enable    (ctl_enable),
  .rd_req        (rd_req),
  .rd_ack        (rd_ack),
  .rd_addr       (rd_addr),
  .data_go       (data_go),
  .pix_valid     (pix_valid),
  .rgb_valid     (rgb_valid),
  .evt_underflow (evt_underflow),
  .evt_frame0    (evt_frame0),
  .stat_clr_we   (stat_clr_we),
  .stat_clr_data (stat_clr_data),
  .status        (status),
  .irq           (irq)
);

// File: tb/palette_loader_tb_top.sv
`timescale 1ns/1ps
module palette_loader_tb_top;
  localparam int AW = 32;
  localparam int IDX_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_enable = 1'b0;
  logic [1:0] ctl_load_mode = 2'd0;
  logic ctl_pal_irq_en = 1'b0;
  logic ctl_unf_irq_en = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic rd_req;
  logic [AW-1:0] rd_addr;
  logic rd_ack = 1'b0;
  logic [15:0] rd_data = '0;
  logic [AW-1:0] fetch_ceiling;
  logic data_go;
  logic pix_valid = 1'b0;
  logic [IDX_W-1:0] pix_idx = '0;
  logic rgb_valid;
  logic [11:0] rgb_out;
  logic depth_is8;
  logic evt_frame0 = 1'b0, evt_frame1 = 1'b0, evt_underflow = 1'b0, evt_sync_lost = 1'b0;
  logic stat_clr_we = 1'b0;
  logic [9:0] stat_clr_data = '0;
  logic [9:0] status;
  logic irq;

  int checks = 0;
  int errors = 0;
  int acks = 0;
  int addr_err = 0;
  int go_cnt = 0;
  int seed = 0;
  logic [3:0] hdr = 4'h4;

  always #2 clk = ~clk;

  palette_loader #(.AW(AW), .IDX_W(IDX_W), .SMALL_IDX_W(4)) dut_i (.*);

  function automatic logic [11:0] col(int i, int s);
    return 12'((i * 29 + s * 7 + 3) & 12'hFFF);
  endfunction

  function automatic logic [15:0] mem_word(logic [AW-1:0] a);
    int idx;
    idx = int'((a - base_addr) >> 1);
    if (idx == 0) return {hdr, col(0, seed)};
    return {4'hA, col(idx, seed)};
  endfunction

  // memory responder: one word per two cycles
  always @(negedge clk) begin
    if (rd_ack) rd_ack = 1'b0;
    else if (rd_req) begin
      if (rd_addr != base_addr + AW'(2 * acks)) addr_err++;
      rd_data = mem_word(rd_addr);
      rd_ack  = 1'b1;
      acks++;
    end
  end

  always @(negedge clk) if (data_go) go_cnt++;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clr_stat(logic [9:0] m);
    stat_clr_we = 1'b1; stat_clr_data = m;
    @(negedge clk);
    stat_clr_we = 1'b0; stat_clr_data = '0;
  endtask

  task automatic start_load(logic [1:0] m, logic [3:0] h, int s, logic [AW-1:0] b);
    ctl_enable = 1'b0;
    @(negedge clk);
    clr_stat(10'h3FF);
    @(negedge clk);
    hdr = h; seed = s; base_addr = b; acks = 0; addr_err = 0;
    ctl_load_mode = m;
    ctl_enable = 1'b1;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (status[6]) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic sweep(int s, bit is8, string req);
    int bad = 0;
    for (int i = 0; i < 256; i++) begin
      pix_valid = 1'b1; pix_idx = IDX_W'(i);
      @(negedge clk);
      checks++;
      if (!rgb_valid || rgb_out !== col(is8 ? i : (i & 15), s)) begin
        errors++; bad++;
        if (bad < 5) $display("FAIL %s: idx %0d actual %0h expected %0h", req, i, rgb_out, col(is8 ? i : (i & 15), s));
      end
    end
    pix_valid = 1'b0;
    @(negedge clk);
    chk("R6 valid drop", 32'(rgb_valid), 0);
  endtask

  task automatic pulse(ref logic e);
    e = 1'b1;
    @(negedge clk);
    e = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int g0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state
    chk("reset rd_req", 32'(rd_req), 0);
    chk("reset status R7", 32'(status), 0);
    chk("reset irq R9", 32'(irq), 0);
    chk("reset rgb_valid R6", 32'(rgb_valid), 0);
    chk("reset depth R3", 32'(depth_is8), 0);

    // mode 1, 8-bit table
    g0 = go_cnt;
    start_load(2'd1, 4'h4, 1, 32'h1000_0000);
    wait_done();
    chk("R3 word count 8bpp", 32'(acks), 256);
    chk("R2 addresses", 32'(addr_err), 0);
    chk("R2 ceiling 8bpp", fetch_ceiling, 32'h1000_01FF);
    chk("R3 depth 8", 32'(depth_is8), 1);
    chk("R4 mode1 done flag", 32'(status[6]), 1);
    chk("R4 mode1 no go", 32'(go_cnt - g0), 0);
    repeat (20) @(negedge clk);
    chk("R1 no restart req", 32'(rd_req), 0);
    chk("R1 no restart acks", 32'(acks), 256);
    sweep(1, 1'b1, "R6 lookup 8bpp");

    // R9: load-complete interrupt gated by its enable
    chk("R9 pl irq masked", 32'(irq), 0);
    ctl_pal_irq_en = 1'b1;
    @(negedge clk);
    chk("R9 pl irq enabled", 32'(irq), 1);
    clr_stat(10'h040);
    chk("R8 clear bit6", 32'(status), 0);
    chk("R9 irq low after clear", 32'(irq), 0);
    ctl_pal_irq_en = 1'b0;

    // mode 0, 4-bit table at another base
    g0 = go_cnt;
    start_load(2'd0, 4'h2, 2, 32'h2000_0100);
    wait_done();
    chk("R3 word count 4bpp", 32'(acks), 16);
    chk("R2 addresses 4bpp", 32'(addr_err), 0);
    chk("R2 ceiling 4bpp", fetch_ceiling, 32'h2000_011F);
    chk("R3 depth 4", 32'(depth_is8), 0);
    chk("R4 mode0 done flag", 32'(status[6]), 1);
    chk("R4 mode0 go", 32'(go_cnt - g0), 1);
    sweep(2, 1'b0, "R6 lookup 4bpp");

    // bit 15 set in header: not 8-bit
    start_load(2'd1, 4'hC, 3, 32'h3000_0000);
    wait_done();
    chk("R3 header bit15 count", 32'(acks), 16);
    chk("R3 header bit15 depth", 32'(depth_is8), 0);

    // mode 2: data only
    g0 = go_cnt;
    start_load(2'd2, 4'h4, 4, 32'h4000_0000);
    repeat (6) @(negedge clk);
    chk("R4 mode2 go", 32'(go_cnt - g0), 1);
    chk("R4 mode2 no fetch", 32'(acks), 0);
    chk("R4 mode2 no flag", 32'(status[6]), 0);

    // mode 3: nothing
    g0 = go_cnt;
    start_load(2'd3, 4'h4, 4, 32'h4000_0000);
    repeat (6) @(negedge clk);
    chk("R4 mode3 go", 32'(go_cnt - g0), 0);
    chk("R4 mode3 no fetch", 32'(acks), 0);
    chk("R4 mode3 no flag", 32'(status[6]), 0);

    // abort mid-fetch
    g0 = go_cnt;
    start_load(2'd0, 4'h4, 5, 32'h5000_0000);
    repeat (20) @(negedge clk);
    ctl_enable = 1'b0;
    @(negedge clk);
    chk("R5 req drops", 32'(rd_req), 0);
    repeat (10) @(negedge clk);
    chk("R5 no done flag", 32'(status[6]), 0);
    chk("R5 no go", 32'(go_cnt - g0), 0);
    chk("R5 fetch cut short", 32'(acks < 20), 1);

    // status events and clearing
    clr_stat(10'h3FF);
    chk("R8 clear all", 32'(status), 0);
    pulse(evt_underflow);
    chk("R7 underflow set", 32'(status), 32'h020);
    chk("R9 unf masked", 32'(irq), 0);
    ctl_unf_irq_en = 1'b1;
    @(negedge clk);
    chk("R9 unf enabled", 32'(irq), 1);
    evt_underflow = 1'b1;
    clr_stat(10'h020);
    evt_underflow = 1'b0;
    chk("R8 event wins", 32'(status[5]), 1);
    clr_stat(10'h020);
    chk("R8 unf cleared", 32'(status), 0);
    chk("R9 irq low after unf clear", 32'(irq), 0);
    pulse(evt_frame0);
    chk("R7 frame0 set", 32'(status), 32'h100);
    chk("R9 frame0 irq", 32'(irq), 1);
    clr_stat(10'h200);
    chk("R8 other bit kept", 32'(status), 32'h100);
    pulse(evt_frame1);
    repeat (5) @(negedge clk);
    chk("R7 frames held", 32'(status), 32'h300);
    clr_stat(10'h300);
    chk("R8 frames cleared", 32'(status), 0);
    chk("R9 irq low frames", 32'(irq), 0);
    pulse(evt_sync_lost);
    chk("R7 sync set", 32'(status), 32'h004);
    chk("R9 sync irq", 32'(irq), 1);
    clr_stat(10'h004);
    chk("R9 sync irq cleared", 32'(irq), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule